// File: doc/BRIEF.md
# Pseudo-Sync Pulse Detector for Copy-Protected Video

The block watches a sync line for the narrow extra pulses that analog copy protection places in the vertical blanking interval. A frame start (rising edge of `vsync`) zeroes a line counter. Each falling edge of the line timing input `hsync_n` advances that counter. While the counter lies inside a programmable band of lines, every low pulse on `csync_n` is timed in pixel clocks. The pulse is counted when its width falls between a lower and an upper limit.

When the line counter leaves the last line of the band, the frame is judged. In standard-definition mode, the pulses counted in the final three lines of the band are compared with a threshold taken from a 2-bit code. In progressive mode, the whole band's count is compared with that threshold. The verdict and the frame's pulse count are latched and held until the next judgement. A single select input chooses between built-in presets and the programmed limits.

Top module: `ps_pulse_detect`

## Requirements
- R1: While `rst_n` is low, and after its release until the first judgement, `detect` is 0 and `pulse_count` is 0.
- R2: A rising edge on `vsync` sets the line number to 0. Each falling edge of `hsync_n` then adds one. Only pulses that end while the line number is within `line_first`..`line_last` inclusive are counted, and pulses in other lines are ignored.
- R3: A pulse is the time `csync_n` is low. Its width c is the number of rising clock edges at which `csync_n` is sampled low. It qualifies when min <= c <= max.
- R4: When `oversample` is 1, c is halved (rounded down) before it is compared with the limits.
- R5: With `progressive` at 0, `detect` is set when the number of qualified pulses in the lines max(line_first, line_last-2)..line_last reaches the threshold. The threshold is coded by `need_sel`: 00 means 6, 01 means 4, 10 means 5, 11 means 7.
- R6: With `progressive` at 1, the same threshold is applied to the count of qualified pulses over the whole band.
- R7: With `use_regs` at 0, the block uses min 6, max 9, band 13..21 and threshold 5, and ignores `wid_min`, `wid_max`, `line_first`, `line_last` and `need_sel`.
- R8: The judgement happens on the `hsync_n` falling edge that leaves line `line_last`. It loads `detect` and `pulse_count`, which is the band's total qualified count. Both outputs then hold through the next frame start until the next judgement.
- R9: A pulse whose end is sampled in the same cycle as the judging `hsync_n` edge belongs to line `line_last` and is included in that judgement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsync_n | input | 1 | Line timing, falling edge starts a line |
| vsync | input | 1 | Frame start, rising edge |
| csync_n | input | 1 | Sync line carrying the measured low pulses |
| use_regs | input | 1 | 1 selects programmed limits, 0 selects presets |
| oversample | input | 1 | Pixel clock at twice nominal rate |
| progressive | input | 1 | 0 tail-of-band judgement, 1 whole-band judgement |
| wid_min | input | 4 | Lowest qualifying width |
| wid_max | input | 4 | Highest qualifying width |
| line_first | input | 6 | First line of the band |
| line_last | input | 6 | Last line of the band |
| need_sel | input | 2 | Threshold code |
| detect | output | 1 | Protection found in last judged frame |
| pulse_count | output | 8 | Qualified pulses in last judged band |

## Verification
Two events can fall in the same cycle: the end of a pulse in the last band line, and the line edge that triggers the judgement. The bench provokes this by holding a pulse low until the exact clock edge on which `hsync_n` falls. In one directed frame, that pulse is the one that lifts the tail count to the threshold. Only a design that counts the pulse before it latches the verdict reports both the flag and the full count that the bench model predicts.

// File: rtl/ps_pulse_detect.sv
module ps_pulse_detect #(
  parameter int LINE_W = 6,
  parameter int WID_W  = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync_n,
  input  logic              vsync,
  input  logic              csync_n,
  input  logic              use_regs,
  input  logic              oversample,
  input  logic              progressive,
  input  logic [WID_W-1:0]  wid_min,
  input  logic [WID_W-1:0]  wid_max,
  input  logic [LINE_W-1:0] line_first,
  input  logic [LINE_W-1:0] line_last,
  input  logic [1:0]        need_sel,
  output logic              detect,
  output logic [CNT_W-1:0]  pulse_count
);
  localparam int LC_W   = LINE_W + 1;
  localparam int MC_W   = WID_W + 2;
  localparam int P_MIN  = 6;
  localparam int P_MAX  = 9;
  localparam int P_LO   = 13;
  localparam int P_HI   = 21;
  localparam int P_NEED = 5;

  logic hs_q, vs_q, cs_q;
  logic [LC_W-1:0]  line;
  logic [MC_W-1:0]  lowcnt;
  logic [CNT_W-1:0] tot, tail;
  logic [2:0]       need_reg;

  wire hs_fall = hs_q & ~hsync_n;
  wire vs_rise = vsync & ~vs_q;
  wire cs_rise = ~cs_q & csync_n;

  wire [WID_W-1:0]  wmin  = use_regs ? wid_min    : WID_W'(P_MIN);
  wire [WID_W-1:0]  wmax  = use_regs ? wid_max    : WID_W'(P_MAX);
  wire [LINE_W-1:0] lfirst = use_regs ? line_first : LINE_W'(P_LO);
  wire [LINE_W-1:0] llast  = use_regs ? line_last  : LINE_W'(P_HI);

  always_comb begin
    case (need_sel)
      2'b00:   need_reg = 3'd6;
      2'b01:   need_reg = 3'd4;
      2'b10:   need_reg = 3'd5;
      default: need_reg = 3'd7;
    endcase
  end

  wire [2:0] need = use_regs ? need_reg : 3'(P_NEED);

  wire [MC_W-1:0] meas = oversample ? (lowcnt >> 1) : lowcnt;
  wire in_win  = (line >= LC_W'(lfirst)) && (line <= LC_W'(llast));
  wire in_tail = in_win && ((line + LC_W'(2)) >= LC_W'(llast));
  wire hit = cs_rise && in_win && (meas >= MC_W'(wmin)) && (meas <= MC_W'(wmax));

  wire [CNT_W-1:0] tot_n  = (hit && ~&tot) ? tot + 1'b1 : tot;
  wire [CNT_W-1:0] tail_n = (hit && in_tail && ~&tail) ? tail + 1'b1 : tail;
  wire judge = hs_fall && !vs_rise && (line == LC_W'(llast));
  wire [CNT_W-1:0] basis = progressive ? tot_n : tail_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q        <= 1'b1;
      vs_q        <= 1'b0;
      cs_q        <= 1'b1;
      line        <= '1;
      lowcnt      <= '0;
      tot         <= '0;
      tail        <= '0;
      detect      <= 1'b0;
      pulse_count <= '0;
    end else begin
      hs_q   <= hsync_n;
      vs_q   <= vsync;
      cs_q   <= csync_n;
      lowcnt <= csync_n ? '0 : (&lowcnt ? lowcnt : lowcnt + 1'b1);
      if (vs_rise) begin
        line <= '0;
        tot  <= '0;
        tail <= '0;
      end else begin
        if (hs_fall && ~&line) line <= line + 1'b1;
        tot  <= tot_n;
        tail <= tail_n;
      end
      if (judge) begin
        pulse_count <= tot_n;
        detect      <= basis >= CNT_W'(need);
      end
    end
  end
endmodule

// File: rtl/ps_pulse_detect_chk.sv
module ps_pulse_detect_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hsync_n,
  input logic             detect,
  input logic [CNT_W-1:0] pulse_count
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!detect && pulse_count == '0));

  // R8
  flag_moves_on_line_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(detect) |-> ($past(!hsync_n) && $past(hsync_n, 2)));

  // R8
  count_moves_on_line_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pulse_count) |-> ($past(!hsync_n) && $past(hsync_n, 2)));

  // R5
  flag_needs_pulses_chk: assert property (@(posedge clk) disable iff (!rst_n)
    detect |-> (pulse_count >= CNT_W'(4)));
endmodule

bind ps_pulse_detect ps_pulse_detect_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .hsync_n(hsync_n),
  .detect(detect),
  .pulse_count(pulse_count)
);

// File: tb/sim_ps_pulse_detect.sv
module sim_ps_pulse_detect;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync_n = 1'b1, vsync = 1'b0, csync_n = 1'b1;
  logic use_regs = 1'b0, oversample = 1'b0, progressive = 1'b0;
  logic [3:0] wid_min = 4'd0, wid_max = 4'd0;
  logic [5:0] line_first = 6'd0, line_last = 6'd0;
  logic [1:0] need_sel = 2'd0;
  logic detect;
  logic [7:0] pulse_count;

  int nchk = 0, nfail = 0;
  bit have_prev = 0;
  int prev_det = 0, prev_cnt = 0;

  always #10 clk = ~clk;

  ps_pulse_detect u0 (
    .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .vsync(vsync), .csync_n(csync_n),
    .use_regs(use_regs), .oversample(oversample), .progressive(progressive),
    .wid_min(wid_min), .wid_max(wid_max), .line_first(line_first), .line_last(line_last),
    .need_sel(need_sel), .detect(detect), .pulse_count(pulse_count)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int need_of(input int sel);
    case (sel)
      0: return 6;
      1: return 4;
      2: return 5;
      default: return 7;
    endcase
  endfunction

  function automatic bit qual(input int w, input bit ov, input int mn, input int mx);
    int c = ov ? w / 2 : w;
    return (c >= mn) && (c <= mx);
  endfunction

  task automatic drive_line(input int np, input int ws [4], input bit touch);
    hsync_n = 1'b0;
    csync_n = 1'b1;
    repeat (4) @(negedge clk);
    hsync_n = 1'b1;
    for (int k = 0; k < np; k++) begin
      repeat (3) @(negedge clk);
      csync_n = 1'b0;
      repeat (ws[k]) @(negedge clk);
      if (!(touch && k == np - 1)) csync_n = 1'b1;
    end
    if (!(touch && np > 0)) repeat (3) @(negedge clk);
  endtask

  task automatic run_frame(input bit ur, input bit ov, input bit pr,
                           input int mn, input int mx, input int ls, input int le,
                           input int sel, input int dnp, input int dw);
    int emn, emx, els, ele, need, tot, tl, hi, exp_det;
    string tag;
    use_regs = ur; oversample = ov; progressive = pr;
    wid_min = 4'(mn); wid_max = 4'(mx);
    line_first = 6'(ls); line_last = 6'(le); need_sel = 2'(sel);
    emn = ur ? mn : 6; emx = ur ? mx : 9;
    els = ur ? ls : 13; ele = ur ? le : 21;
    need = ur ? need_of(sel) : 5;
    hi = ov ? 2 * emx + 3 : emx + 3;
    vsync = 1'b1;
    repeat (2) @(negedge clk);
    vsync = 1'b0;
    repeat (3) @(negedge clk);
    if (have_prev) begin
      check(detect == 1'(prev_det), "R8 flag held over frame start", int'(detect), prev_det);
      check(pulse_count == 8'(prev_cnt), "R8 count held over frame start", int'(pulse_count), prev_cnt);
    end
    tot = 0; tl = 0;
    for (int L = 1; L <= ele + 2; L++) begin
      int np;
      int ws [4];
      bit touch;
      if (dnp >= 0) begin
        np = (L == ele) ? dnp : 0;
        for (int k = 0; k < 4; k++) ws[k] = dw;
        touch = (L == ele);
      end else begin
        np = $urandom_range(0, 3);
        for (int k = 0; k < 4; k++) ws[k] = $urandom_range(1, hi);
        touch = ($urandom_range(0, 3) == 0);
      end
      for (int k = 0; k < np; k++)
        if (L >= els && L <= ele && qual(ws[k], ov, emn, emx)) begin
          tot++;
          if (L >= ele - 2) tl++;
        end
      drive_line(np, ws, touch);
    end
    hsync_n = 1'b0; csync_n = 1'b1;
    repeat (4) @(negedge clk);
    hsync_n = 1'b1;
    repeat (2) @(negedge clk);
    exp_det = ((pr ? tot : tl) >= need) ? 1 : 0;
    tag = !ur ? "R7 presets" : (pr ? "R6 whole band" : "R5 tail lines");
    check(detect == 1'(exp_det), {tag, " flag, R2 band"}, int'(detect), exp_det);
    check(pulse_count == 8'(tot), ov ? "R4 halved width count" : "R3 width window count",
          int'(pulse_count), tot);
    have_prev = 1; prev_det = exp_det; prev_cnt = tot;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired, R8 judgement never reached");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(detect == 1'b0, "R1 flag in reset", int'(detect), 0);
    check(pulse_count == 8'd0, "R1 count in reset", int'(pulse_count), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(detect == 1'b0 && pulse_count == 8'd0, "R1 after release", int'(pulse_count), 0);

    // R9: the fourth pulse ends on the judging edge and decides the verdict
    run_frame(1, 0, 0, 2, 6, 5, 8, 1, 4, 4);
    // R3 boundaries: widths exactly at min and at max
    run_frame(1, 0, 0, 3, 7, 4, 9, 2, 4, 3);
    run_frame(1, 0, 1, 3, 7, 4, 9, 1, 4, 7);
    run_frame(1, 0, 1, 3, 7, 4, 9, 1, 4, 8);
    // R4 boundaries: halved width lands on max, and just below min
    run_frame(1, 1, 1, 3, 6, 2, 6, 1, 4, 13);
    run_frame(1, 1, 1, 3, 6, 2, 6, 1, 4, 5);
    // R7: wild register values ignored
    run_frame(0, 0, 0, 1, 15, 1, 40, 1, -1, 0);
    run_frame(0, 1, 1, 0, 2, 30, 31, 3, -1, 0);

    for (int f = 0; f < 26; f++) begin
      int mn = $urandom_range(1, 6);
      int mx = mn + $urandom_range(0, 6);
      int ls = $urandom_range(1, 10);
      int le = ls + $urandom_range(0, 10);
      run_frame(($urandom_range(0, 4) != 0), $urandom_range(0, 1), $urandom_range(0, 1),
                mn, mx, ls, le, $urandom_range(0, 3), -1, 0);
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule